// File: doc/BRIEF.md
# Host-to-Board Bus Mode Controller

This block connects a host I/O port to an on-board local bus. The local bus has a low byte lane, a high byte lane, a 22-bit address and a 3-bit mode code. The block answers a window of sixteen host I/O addresses. The low nibble of the host address names the operation, so the command and its data arrive in a single host access. The block turns each accepted access into one registered cycle of mode code, address and lane drive on the local bus. For reads, it captures the returned bytes for the host.

A 22-bit address counter supplies the address for every memory transfer and advances after each one. The host sets it in two steps: a page write gives the upper bits and a counter write gives the lower sixteen. The compute array can also request stream cycles. In a stream cycle one byte goes out on the low lane while a byte comes back from memory on the high lane, at the counter address. A reload command starts the configuration loader and holds the block busy until the loader reports completion.

Top module: `hostbus_mode_ctrl`

## Requirements
- R1: After reset the mode output is 7 (idle), neither lane is driven, both lane outputs are zero, busy and ack are low, read data is zero, the stream-valid flag is low and the bus address is zero.
- R2: A host request whose address bits above the low nibble differ from the window base is ignored. The mode stays 7, no ack is given, and the counter is unchanged.
- R3: A request that is accepted in the cycle after clock edge k sets the mode output for the single cycle after edge k. The host address nibble selects the mode as follows: 0 gives 0 (reload), 1 gives 1 (counter write), 3 gives 3 (16-bit write), 4 gives 4 (16-bit read), 5 gives 5 (8-bit write) and 6 gives 6 (8-bit read). Nibble 2 is a page write and leaves the mode at 7. Nibbles 7 to 15 leave the mode at 7. After that cycle the mode returns to 7.
- R4: Nibble 2 stores the low 6 bits of the host data as the page. Nibble 1 loads the counter with the page in bits 21:16 and the host data in bits 15:0.
- R5: Each memory cycle (modes 2 to 6) presents the counter on the bus address. The counter then increments by one and wraps from 0x3FFFFF to 0. The bus address holds its value in all other cycles.
- R6: In mode 3 the low lane carries host data bits 7:0 and the high lane carries bits 15:8, and both lanes are driven. In mode 5 only the low lane is driven, with data bits 7:0. Modes 0, 1, 4, 6 and 7 drive neither lane, and the lane outputs read zero.
- R7: At the end of a mode-4 cycle the read data becomes {high lane, low lane}. At the end of a mode-6 cycle it becomes {8'h00, low lane}. The read data holds its value otherwise.
- R8: Every accepted host access gives a one-cycle ack two clock edges after the edge that accepts it. Read data is valid while ack is high.
- R9: A stream request with no accepted host access and no busy state produces mode 2. The low lane is driven with the array byte and the high lane is not driven. At the end of that cycle the high-lane input is captured as the array read byte, and the stream-valid flag is high for one cycle.
- R10: When an in-window host request and a stream request arrive in the same cycle, the host operation is performed and the stream request is dropped.
- R11: Nibble 0 raises busy together with mode 0. While busy is high, host and stream requests are ignored: no ack, mode 7, no counter change. Busy clears at the edge where the done input is sampled high.
- R12: The done input has no effect while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | One-cycle host access strobe |
| hst_addr | input | 10 | Host I/O address; low nibble is the operation |
| hst_wdata | input | 16 | Host data carried with the access |
| hst_rdata | output | 16 | Captured read data |
| hst_ack | output | 1 | Access completion pulse |
| busy | output | 1 | Configuration reload in progress |
| cfg_done | input | 1 | Configuration loader finished |
| arr_req | input | 1 | Stream cycle request from the compute array |
| arr_wbyte | input | 8 | Byte the array writes on the low lane |
| arr_rbyte | output | 8 | Byte read for the array from the high lane |
| arr_rvalid | output | 1 | Array read byte updated |
| bus_mode | output | 3 | Local bus mode code |
| bus_addr | output | 22 | Local bus address |
| ld_out | output | 8 | Low lane drive value |
| ld_oe | output | 1 | Low lane drive enable |
| hd_out | output | 8 | High lane drive value |
| hd_oe | output | 1 | High lane drive enable |
| ld_in | input | 8 | Low lane read value |
| hd_in | input | 8 | High lane read value |

## Verification
The bench builds the block with its default parameters: a 10-bit host address, window base 0x30, a 22-bit local address and 8-bit lanes. At these values the page register is 6 bits wide. This lets the bench load the counter with all ones and observe the wrap from the top of the 22-bit space to zero in two consecutive reads. A byte-wide memory model for each lane, indexed by the low address byte, returns known contents. Write-then-read round trips through both lanes and through the stream path can therefore be checked against values computed in the bench.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [2:0] {
    MODE_RELOAD = 3'd0,
    MODE_CNTWR  = 3'd1,
    MODE_STREAM = 3'd2,
    MODE_WR16   = 3'd3,
    MODE_RD16   = 3'd4,
    MODE_WR8    = 3'd5,
    MODE_RD8    = 3'd6,
    MODE_IDLE   = 3'd7
  } bmode_e;

  localparam logic [3:0] OP_RELOAD = 4'd0;
  localparam logic [3:0] OP_CNT    = 4'd1;
  localparam logic [3:0] OP_PAGE   = 4'd2;
  localparam logic [3:0] OP_WR16   = 4'd3;
  localparam logic [3:0] OP_RD16   = 4'd4;
  localparam logic [3:0] OP_WR8    = 4'd5;
  localparam logic [3:0] OP_RD8    = 4'd6;

  function automatic logic mode_is_mem(bmode_e m);
    return (m == MODE_STREAM) || (m == MODE_WR16) || (m == MODE_RD16) ||
           (m == MODE_WR8) || (m == MODE_RD8);
  endfunction
endpackage

// File: rtl/hbc_decode.sv
module hbc_decode
  import hbc_pkg::*;
#(
  parameter int HOST_AW = 10,
  parameter logic [HOST_AW-5:0] WIN_BASE = 6'h30
) (
  input  logic               req,
  input  logic [HOST_AW-1:0] addr,
  input  logic               busy,
  input  logic               arr_req,
  output logic               host_go,
  output logic               arr_go,
  output bmode_e             mode_nxt,
  output logic               cnt_ld,
  output logic               page_ld,
  output logic               reload,
  output logic               mem_go
);
  logic       in_win;
  logic [3:0] op;

  always_comb begin
    in_win  = req && (addr[HOST_AW-1:4] == WIN_BASE);
    op      = addr[3:0];
    host_go = in_win && !busy;
    // host access takes priority over an array stream request
    arr_go  = arr_req && !busy && !in_win;
    mode_nxt = MODE_IDLE;
    if (host_go) begin
      case (op)
        OP_RELOAD: mode_nxt = MODE_RELOAD;
        OP_CNT:    mode_nxt = MODE_CNTWR;
        OP_WR16:   mode_nxt = MODE_WR16;
        OP_RD16:   mode_nxt = MODE_RD16;
        OP_WR8:    mode_nxt = MODE_WR8;
        OP_RD8:    mode_nxt = MODE_RD8;
        default:   mode_nxt = MODE_IDLE;
      endcase
    end else if (arr_go) begin
      mode_nxt = MODE_STREAM;
    end
    cnt_ld  = host_go && (op == OP_CNT);
    page_ld = host_go && (op == OP_PAGE);
    reload  = host_go && (op == OP_RELOAD);
    mem_go  = mode_is_mem(mode_nxt);
  end
endmodule

// File: rtl/hbc_counter.sv
module hbc_counter #(
  parameter int LOC_AW = 22,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cnt_ld,
  input  logic                page_ld,
  input  logic                inc,
  input  logic [2*LANE_W-1:0] din,
  output logic [LOC_AW-1:0]   cnt
);
  localparam int DW     = 2 * LANE_W;
  localparam int PAGE_W = LOC_AW - DW;

  logic [LOC_AW-1:0] cnt_q, cnt_d, load_val;

  generate
    if (PAGE_W > 0) begin : g_page
      logic [PAGE_W-1:0] page_q, page_d;
      always_comb page_d = page_ld ? din[PAGE_W-1:0] : page_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) page_q <= '0;
        else        page_q <= page_d;
      end
      assign load_val = {page_q, din};
    end else begin : g_nopage
      assign load_val = din[LOC_AW-1:0];
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_ld)   cnt_d = load_val;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  assert_cnt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> cnt_q[DW-1:0] == $past(din));
endmodule

// File: rtl/hbc_lanes.sv
module hbc_lanes
  import hbc_pkg::*;
#(
  parameter int LOC_AW = 22,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bmode_e              mode_nxt,
  input  logic                mem_go,
  input  logic [LOC_AW-1:0]   cnt,
  input  logic [2*LANE_W-1:0] wdata,
  input  logic [LANE_W-1:0]   arr_wbyte,
  input  logic [LANE_W-1:0]   ld_in,
  input  logic [LANE_W-1:0]   hd_in,
  output bmode_e              mode_q,
  output logic [LOC_AW-1:0]   addr_q,
  output logic [LANE_W-1:0]   ld_q,
  output logic                ld_oe_q,
  output logic [LANE_W-1:0]   hd_q,
  output logic                hd_oe_q,
  output logic [2*LANE_W-1:0] rdata_q,
  output logic [LANE_W-1:0]   arb_q,
  output logic                arv_q
);
  localparam int DW = 2 * LANE_W;

  bmode_e            mode_d;
  logic [LOC_AW-1:0] addr_d;
  logic [LANE_W-1:0] ld_d, hd_d, arb_d;
  logic              ld_oe_d, hd_oe_d, arv_d;
  logic [DW-1:0]     rdata_d;
  logic              mem_act;

  always_comb begin
    mode_d  = mode_nxt;
    addr_d  = mem_go ? cnt : addr_q;
    ld_d    = '0;
    hd_d    = '0;
    ld_oe_d = 1'b0;
    hd_oe_d = 1'b0;
    case (mode_nxt)
      MODE_WR16: begin
        ld_d = wdata[LANE_W-1:0];  ld_oe_d = 1'b1;
        hd_d = wdata[DW-1:LANE_W]; hd_oe_d = 1'b1;
      end
      MODE_WR8:    begin ld_d = wdata[LANE_W-1:0]; ld_oe_d = 1'b1; end
      MODE_STREAM: begin ld_d = arr_wbyte;         ld_oe_d = 1'b1; end
      default: ;
    endcase
    // capture returned bytes at the end of the current bus cycle
    rdata_d = rdata_q;
    if (mode_q == MODE_RD16)     rdata_d = {hd_in, ld_in};
    else if (mode_q == MODE_RD8) rdata_d = {{LANE_W{1'b0}}, ld_in};
    arv_d = (mode_q == MODE_STREAM);
    arb_d = arv_d ? hd_in : arb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      addr_q  <= '0;
      ld_q    <= '0;
      ld_oe_q <= 1'b0;
      hd_q    <= '0;
      hd_oe_q <= 1'b0;
      rdata_q <= '0;
      arb_q   <= '0;
      arv_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      addr_q  <= addr_d;
      ld_q    <= ld_d;
      ld_oe_q <= ld_oe_d;
      hd_q    <= hd_d;
      hd_oe_q <= hd_oe_d;
      rdata_q <= rdata_d;
      arb_q   <= arb_d;
      arv_q   <= arv_d;
    end
  end

  assign mem_act = mode_is_mem(mode_q);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IDLE) |-> (!ld_oe_q && !hd_oe_q));
  assert_dual_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_oe_q && hd_oe_q) |-> (mode_q == MODE_WR16));
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_act && $past(mem_act) && $past(mode_nxt) != MODE_CNTWR) |->
      (addr_q == $past(addr_q) + 1'b1));
  assert_stream_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arv_q |-> ($past(mode_q) == MODE_STREAM));
endmodule

// File: rtl/hostbus_mode_ctrl.sv
module hostbus_mode_ctrl
  import hbc_pkg::*;
#(
  parameter int HOST_AW = 10,
  parameter logic [HOST_AW-5:0] WIN_BASE = 6'h30,
  parameter int LOC_AW = 22,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_req,
  input  logic [HOST_AW-1:0]  hst_addr,
  input  logic [2*LANE_W-1:0] hst_wdata,
  output logic [2*LANE_W-1:0] hst_rdata,
  output logic                hst_ack,
  output logic                busy,
  input  logic                cfg_done,
  input  logic                arr_req,
  input  logic [LANE_W-1:0]   arr_wbyte,
  output logic [LANE_W-1:0]   arr_rbyte,
  output logic                arr_rvalid,
  output logic [2:0]          bus_mode,
  output logic [LOC_AW-1:0]   bus_addr,
  output logic [LANE_W-1:0]   ld_out,
  output logic                ld_oe,
  output logic [LANE_W-1:0]   hd_out,
  output logic                hd_oe,
  input  logic [LANE_W-1:0]   ld_in,
  input  logic [LANE_W-1:0]   hd_in
);
  logic              host_go, arr_go, cnt_ld, page_ld, reload, mem_go;
  bmode_e            mode_nxt, mode_q;
  logic [LOC_AW-1:0] cnt;
  logic              busy_q, busy_d, ackp_q, ackp_d, ack_q, ack_d;

  hbc_decode #(.HOST_AW(HOST_AW), .WIN_BASE(WIN_BASE)) u_decode (
    .req(hst_req), .addr(hst_addr), .busy(busy_q), .arr_req(arr_req),
    .host_go(host_go), .arr_go(arr_go), .mode_nxt(mode_nxt),
    .cnt_ld(cnt_ld), .page_ld(page_ld), .reload(reload), .mem_go(mem_go)
  );

  hbc_counter #(.LOC_AW(LOC_AW), .LANE_W(LANE_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cnt_ld(cnt_ld), .page_ld(page_ld),
    .inc(mem_go), .din(hst_wdata), .cnt(cnt)
  );

  hbc_lanes #(.LOC_AW(LOC_AW), .LANE_W(LANE_W)) u_lanes (
    .clk(clk), .rst_n(rst_n), .mode_nxt(mode_nxt), .mem_go(mem_go), .cnt(cnt),
    .wdata(hst_wdata), .arr_wbyte(arr_wbyte), .ld_in(ld_in), .hd_in(hd_in),
    .mode_q(mode_q), .addr_q(bus_addr), .ld_q(ld_out), .ld_oe_q(ld_oe),
    .hd_q(hd_out), .hd_oe_q(hd_oe), .rdata_q(hst_rdata), .arb_q(arr_rbyte),
    .arv_q(arr_rvalid)
  );

  always_comb begin
    busy_d = busy_q ? !cfg_done : reload;
    ackp_d = host_go;
    ack_d  = ackp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ackp_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      ackp_q <= ackp_d;
      ack_q  <= ack_d;
    end
  end

  assign busy     = busy_q;
  assign hst_ack  = ack_q;
  assign bus_mode = mode_q;

  assert_reload_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (bus_mode == 3'd0));
  assert_busy_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bus_mode == 3'd7));
  assert_ack_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hst_ack |-> $past(hst_req, 2));
  assert_no_stream_on_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
    host_go |-> !arr_go);
endmodule

// File: tb/hostbus_mode_ctrl_tb.sv
module hostbus_mode_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_req = 1'b0;
  logic [9:0]  hst_addr = '0;
  logic [15:0] hst_wdata = '0;
  logic [15:0] hst_rdata;
  logic        hst_ack, busy, arr_rvalid, ld_oe, hd_oe;
  logic        cfg_done = 1'b0;
  logic        arr_req = 1'b0;
  logic [7:0]  arr_wbyte = '0;
  logic [7:0]  arr_rbyte, ld_out, hd_out, ld_in, hd_in;
  logic [2:0]  bus_mode;
  logic [21:0] bus_addr;

  int compared = 0;
  int mismatched = 0;
  bit cmp_en = 0;
  bit done = 0;

  logic [7:0] mem_lo [256];
  logic [7:0] mem_hi [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign ld_in = mem_lo[bus_addr[7:0]];
  assign hd_in = mem_hi[bus_addr[7:0]];

  hostbus_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ack(hst_ack), .busy(busy),
    .cfg_done(cfg_done), .arr_req(arr_req), .arr_wbyte(arr_wbyte),
    .arr_rbyte(arr_rbyte), .arr_rvalid(arr_rvalid), .bus_mode(bus_mode),
    .bus_addr(bus_addr), .ld_out(ld_out), .ld_oe(ld_oe), .hd_out(hd_out),
    .hd_oe(hd_oe), .ld_in(ld_in), .hd_in(hd_in)
  );

  // behavioural reference state
  int   m_mode, m_addr, m_cnt, m_page, m_ld, m_hd, m_rd, m_arb;
  bit   m_ldoe, m_hdoe, m_ack, m_ackp, m_busy, m_arv;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_mode = 7; m_addr = 0; m_cnt = 0; m_page = 0; m_ld = 0; m_hd = 0; m_rd = 0;
    m_arb = 0; m_ldoe = 0; m_hdoe = 0; m_ack = 0; m_ackp = 0; m_busy = 0; m_arv = 0;
  endtask

  task automatic model_step();
    int lo, hi, op;
    bit win, take;
    lo = mem_lo[m_addr % 256];
    hi = mem_hi[m_addr % 256];
    if (m_mode == 4) m_rd = hi * 256 + lo;
    if (m_mode == 6) m_rd = lo;
    m_arv = (m_mode == 2);
    if (m_arv) m_arb = hi;
    m_ack = m_ackp;
    m_ackp = 0;
    m_mode = 7; m_ld = 0; m_hd = 0; m_ldoe = 0; m_hdoe = 0;
    win = hst_req && (hst_addr[9:4] == 6'h30);
    op = int'(hst_addr[3:0]);
    if (m_busy) begin
      if (cfg_done) m_busy = 0;
    end else if (win) begin
      m_ackp = 1;
      take = (op >= 3 && op <= 6);
      if (op == 0) begin m_mode = 0; m_busy = 1; end
      if (op == 1) begin m_mode = 1; m_cnt = m_page * 65536 + int'(hst_wdata); end
      if (op == 2) m_page = int'(hst_wdata[5:0]);
      if (take) begin
        m_mode = op; m_addr = m_cnt; m_cnt = (m_cnt + 1) % (1 << 22);
        if (op == 3 || op == 5) begin m_ld = int'(hst_wdata[7:0]); m_ldoe = 1; end
        if (op == 3) begin m_hd = int'(hst_wdata[15:8]); m_hdoe = 1; end
      end
    end else if (arr_req) begin
      m_mode = 2; m_addr = m_cnt; m_cnt = (m_cnt + 1) % (1 << 22);
      m_ld = int'(arr_wbyte); m_ldoe = 1;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // per-cycle comparison, then the memory model takes the write of this cycle
  always @(negedge clk) begin
    if (cmp_en) begin
      cmp("R3 bus_mode", 32'(bus_mode), 32'(m_mode));
      cmp("R5 bus_addr", 32'(bus_addr), 32'(m_addr));
      cmp("R6 low lane", {23'd0, ld_oe, ld_out}, {23'd0, m_ldoe, 8'(m_ld)});
      cmp("R6 high lane", {23'd0, hd_oe, hd_out}, {23'd0, m_hdoe, 8'(m_hd)});
      cmp("R7 read data", 32'(hst_rdata), 32'(m_rd));
      cmp("R8 ack", 32'(hst_ack), 32'(m_ack));
      cmp("R9 stream read", {23'd0, arr_rvalid, arr_rbyte}, {23'd0, m_arv, 8'(m_arb)});
      cmp("R11 busy", 32'(busy), 32'(m_busy));
    end
    if (m_mode == 3 || m_mode == 5 || m_mode == 2) mem_lo[m_addr % 256] = 8'(m_ld);
    if (m_mode == 3) mem_hi[m_addr % 256] = 8'(m_hd);
  end

  task automatic host_op(input logic [9:0] a, input logic [15:0] d,
                         output logic [2:0] mode_s, output logic [21:0] addr_s,
                         output logic [1:0] oe_s, output logic ack_s,
                         output logic [15:0] rd_s);
    @(negedge clk); hst_req = 1'b1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_req = 1'b0; mode_s = bus_mode; addr_s = bus_addr; oe_s = {ld_oe, hd_oe};
    @(negedge clk); ack_s = hst_ack; rd_s = hst_rdata;
  endtask

  task automatic arr_op(input logic [7:0] b, output logic [2:0] mode_s,
                        output logic [21:0] addr_s, output logic v_s,
                        output logic [7:0] rb_s);
    @(negedge clk); arr_req = 1'b1; arr_wbyte = b;
    @(negedge clk); arr_req = 1'b0; mode_s = bus_mode; addr_s = bus_addr;
    @(negedge clk); v_s = arr_rvalid; rb_s = arr_rbyte;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      finish_run();
    end
  end

  initial begin
    logic [2:0]  ms;
    logic [21:0] as;
    logic [1:0]  os;
    logic        ks, vs;
    logic [15:0] rs;
    logic [7:0]  bs;
    for (int i = 0; i < 256; i++) begin
      mem_lo[i] = 8'(i) ^ 8'hA5;
      mem_hi[i] = 8'(i + 8'h3C);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1 mode", 32'(bus_mode), 32'd7);
    cmp("R1 lanes", {ld_oe, hd_oe, ld_out, hd_out}, 32'd0);
    cmp("R1 flags", {busy, hst_ack, arr_rvalid}, 32'd0);
    cmp("R1 rdata", 32'(hst_rdata), 32'd0);
    cmp("R1 addr", 32'(bus_addr), 32'd0);
    rst_n = 1'b1;
    cmp_en = 1;

    // R4 page and counter load, R6 16-bit write
    host_op(10'h302, 16'h0000, ms, as, os, ks, rs);
    cmp("R3 page write mode", 32'(ms), 32'd7);
    host_op(10'h301, 16'h0010, ms, as, os, ks, rs);
    cmp("R3 counter write mode", 32'(ms), 32'd1);
    host_op(10'h303, 16'hBEEF, ms, as, os, ks, rs);
    cmp("R4 loaded address", 32'(as), 32'h10);
    cmp("R6 wr16 both lanes", 32'(os), 32'b11);
    cmp("R8 ack after write", 32'(ks), 32'd1);
    host_op(10'h303, 16'h1234, ms, as, os, ks, rs);
    cmp("R5 increment", 32'(as), 32'h11);
    host_op(10'h301, 16'h0010, ms, as, os, ks, rs);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R3 rd16 mode", 32'(ms), 32'd4);
    cmp("R7 rd16 data", 32'(rs), 32'hBEEF);
    host_op(10'h305, 16'h995A, ms, as, os, ks, rs);
    cmp("R6 wr8 low lane only", 32'(os), 32'b10);
    host_op(10'h301, 16'h0011, ms, as, os, ks, rs);
    host_op(10'h306, 16'h0000, ms, as, os, ks, rs);
    cmp("R7 rd8 data", 32'(rs), 32'h005A);

    // R9 array stream
    host_op(10'h301, 16'h0020, ms, as, os, ks, rs);
    arr_op(8'h11, ms, as, vs, bs);
    cmp("R9 stream mode", 32'(ms), 32'd2);
    cmp("R9 stream addr", 32'(as), 32'h20);
    cmp("R9 stream byte", {vs, bs}, {1'b1, 8'h5C});
    arr_op(8'h22, ms, as, vs, bs);
    cmp("R9 stream byte 2", {vs, bs}, {1'b1, 8'h5D});
    host_op(10'h301, 16'h0020, ms, as, os, ks, rs);
    host_op(10'h306, 16'h0000, ms, as, os, ks, rs);
    cmp("R9 stream wrote low lane", 32'(rs), 32'h0011);

    // R10 host wins over array; counter is 0x21
    @(negedge clk); hst_req = 1'b1; hst_addr = 10'h305; hst_wdata = 16'h0077;
    arr_req = 1'b1; arr_wbyte = 8'h99;
    @(negedge clk); hst_req = 1'b0; arr_req = 1'b0;
    cmp("R10 host mode chosen", 32'(bus_mode), 32'd5);
    cmp("R10 host address", 32'(bus_addr), 32'h21);
    @(negedge clk);
    cmp("R10 stream dropped", 32'(arr_rvalid), 32'd0);

    // R2 out of window
    host_op(10'h203, 16'h4444, ms, as, os, ks, rs);
    cmp("R2 idle mode", 32'(ms), 32'd7);
    cmp("R2 no ack", 32'(ks), 32'd0);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R2 counter untouched", 32'(as), 32'h22);

    // R3 unused nibbles
    host_op(10'h307, 16'h0000, ms, as, os, ks, rs);
    cmp("R3 nibble 7 idle", {29'd0, ms}, 32'd7);
    cmp("R3 nibble 7 acked", 32'(ks), 32'd1);
    host_op(10'h30F, 16'h0000, ms, as, os, ks, rs);
    cmp("R3 nibble 15 idle", 32'(ms), 32'd7);

    // R11 reload interlock
    host_op(10'h300, 16'h0000, ms, as, os, ks, rs);
    cmp("R11 reload mode", 32'(ms), 32'd0);
    cmp("R11 busy set", 32'(busy), 32'd1);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R11 host blocked mode", 32'(ms), 32'd7);
    cmp("R11 host blocked ack", 32'(ks), 32'd0);
    arr_op(8'h33, ms, as, vs, bs);
    cmp("R11 array blocked", {ms, vs}, {3'd7, 1'b0});
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
    cmp("R11 busy cleared", 32'(busy), 32'd0);

    // R12 done while idle
    @(negedge clk); cfg_done = 1'b1;
    @(negedge clk); cfg_done = 1'b0;
    cmp("R12 busy stays low", 32'(busy), 32'd0);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R12 access accepted", {ms, ks}, {3'd4, 1'b1});
    cmp("R12 counter unchanged by blocked ops", 32'(as), 32'h23);

    // R5 wrap at the top of the address space
    host_op(10'h302, 16'h003F, ms, as, os, ks, rs);
    host_op(10'h301, 16'hFFFF, ms, as, os, ks, rs);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R5 top address", 32'(as), 32'h3FFFFF);
    cmp("R7 top data", 32'(rs), 32'h3B5A);
    host_op(10'h304, 16'h0000, ms, as, os, ks, rs);
    cmp("R5 wrapped address", 32'(as), 32'h0);
    cmp("R7 wrapped data", 32'(rs), 32'h3CA5);

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      finish_run();
    end
  end
endmodule